// File: doc/BRIEF.md
# Amplifier Protection and Mute Sequencer

This block supervises a two-channel switching power stage. It receives flags that are already digital: supply over-voltage and under-voltage, two over-current levels, one speaker-present flag per channel, an input clipping flag, and the mute and sleep controls. From these it decides whether the output stages may switch. It also drives a hard-mute status output, a gain-reduction request, a clipping indicator, a low-power request and a set of status bits that a register file can sample.

Each protection cause has its own recovery rule. A supply fault clears as soon as the rail is back in range. An over-current shutdown stays latched until the mute control is raised again. A missing speaker at power-up holds the stage off until both speakers are present. Every return to operation waits for a fixed unmute delay. The clock frequency and the delay in milliseconds are parameters, and the cycle count of the delay is derived from them.

Top module: `amp_guard`

## Requirements
- R1: While the synchronized over-voltage or under-voltage flag is high, `stage_en_o` is 0 and `hmute_o` is 1. When the flag clears, the stage returns without any latching, after the unmute delay of R5.
- R2: The over-current limit flag drives `gain_cut_o` high while it is present and does not disable the stage.
- R3: A high over-current shutdown flag disables the stage and sets `oc_latched_o`. The latch holds after the flag clears and is released only by a rising edge of the synchronized mute input while the shutdown flag is low, or by reset.
- R4: While mute is high, `stage_en_o` is 0 and `hmute_o` is 1.
- R5: Once every muting cause is clear, `stage_en_o` rises after exactly DLY clock edges, where DLY = CLK_HZ/1000*UNMUTE_MS. Any cause that appears during this wait aborts it, and the count restarts from zero.
- R6: After reset, `spk_wait_o` is 1 and the stage stays off until both speaker flags are seen high together. From then on, losing a speaker flag has no effect.
- R7: While sleep is high, `lowpwr_o` is 1 and the stage is off.
- R8: `clip_ind_o` follows the clipping flag with no latching.
- R9: Every flag passes through a two-flop synchronizer, so an input change reaches the outputs after the second rising clock edge.
- R10: During reset, `stage_en_o` = 0, `hmute_o` = 1, `oc_latched_o` = 0, `spk_wait_o` = 1 and `gain_cut_o` = 0.
- R11: `stage_en_o` is high only when no muting cause is active. `hmute_o` is always its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ovp_i | input | 1 | Supply above the upper limit |
| uvp_i | input | 1 | Supply below the lower limit |
| ocl_i | input | 1 | Over-current limit level reached |
| ocs_i | input | 1 | Over-current shutdown level reached |
| spk_ok_i | input | 2 | Speaker present, one bit per channel |
| clip_i | input | 1 | Input clipping flag |
| mute_i | input | 1 | Mute control |
| sleep_i | input | 1 | Sleep control |
| stage_en_o | output | 1 | Output stages may switch |
| hmute_o | output | 1 | Hard-mute status |
| gain_cut_o | output | 1 | Request reduced input gain |
| clip_ind_o | output | 1 | Clipping indicator |
| lowpwr_o | output | 1 | Low-power request |
| oc_latched_o | output | 1 | Over-current shutdown is latched |
| spk_wait_o | output | 1 | Start-up speaker check still pending |
| supply_flt_o | output | 1 | Supply fault currently present |

## Verification
The embedded assertions check, on every cycle, that a synchronized supply fault, sleep, mute or pending speaker check keeps the stage off. They also check that the over-current latch holds unless mute rises, and that the stage is never enabled in a cycle that follows an active cause. Only the bench scenarios can show the exact length of the unmute delay, that a re-mute restarts the count, the two-edge synchronizer latency, and that the latch really releases on a mute pulse and the stage then comes back.

// File: rtl/amp_guard_pkg.sv
package amp_guard_pkg;
    localparam int NFLAG    = 9;
    localparam int F_OV     = 0;
    localparam int F_UV     = 1;
    localparam int F_OCL    = 2;
    localparam int F_OCS    = 3;
    localparam int F_SPK0   = 4;
    localparam int F_SPK1   = 5;
    localparam int F_CLIP   = 6;
    localparam int F_MUTE   = 7;
    localparam int F_SLEEP  = 8;

    typedef struct packed {
        logic oc_lat;
        logic spk_blk;
        logic mute_prev;
    } guard_st_t;
endpackage

// File: rtl/amp_guard_sync.sv
module amp_guard_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg1_q;
    logic [W-1:0] stg2_q;

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg1_q[g] <= 1'b0;
                stg2_q[g] <= 1'b0;
            end else begin
                stg1_q[g] <= async_i[g];
                stg2_q[g] <= stg1_q[g];
            end
        end
    end

    assign sync_o = stg2_q;
endmodule

// File: rtl/amp_guard_timer.sv
module amp_guard_timer #(
    parameter int unsigned DLY = 20_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    output logic ready_o
);
    localparam int unsigned CW = (DLY > 2) ? $clog2(DLY) : 1;
    localparam logic [CW-1:0] LAST = CW'(DLY - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ready;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (hold_i) begin
            tmr_d.cnt   = '0;
            tmr_d.ready = 1'b0;
        end else if (!tmr_q.ready) begin
            if (tmr_q.cnt == LAST) tmr_d.ready = 1'b1;
            else                   tmr_d.cnt   = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign ready_o = tmr_q.ready;

    AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> !tmr_q.ready && tmr_q.cnt == '0) else $error("hold"); // R5
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= LAST) else $error("bound"); // R5
endmodule

// File: rtl/amp_guard.sv
module amp_guard
    import amp_guard_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned UNMUTE_MS = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ovp_i,
    input  logic       uvp_i,
    input  logic       ocl_i,
    input  logic       ocs_i,
    input  logic [1:0] spk_ok_i,
    input  logic       clip_i,
    input  logic       mute_i,
    input  logic       sleep_i,
    output logic       stage_en_o,
    output logic       hmute_o,
    output logic       gain_cut_o,
    output logic       clip_ind_o,
    output logic       lowpwr_o,
    output logic       oc_latched_o,
    output logic       spk_wait_o,
    output logic       supply_flt_o
);
    localparam int unsigned DLY = (CLK_HZ / 1000) * UNMUTE_MS;

    logic [NFLAG-1:0] raw_w, syn_w;
    logic supply_w, cause_w, ready_w, mute_rise_w;
    guard_st_t st_d, st_q;

    assign raw_w[F_OV]    = ovp_i;
    assign raw_w[F_UV]    = uvp_i;
    assign raw_w[F_OCL]   = ocl_i;
    assign raw_w[F_OCS]   = ocs_i;
    assign raw_w[F_SPK0]  = spk_ok_i[0];
    assign raw_w[F_SPK1]  = spk_ok_i[1];
    assign raw_w[F_CLIP]  = clip_i;
    assign raw_w[F_MUTE]  = mute_i;
    assign raw_w[F_SLEEP] = sleep_i;

    amp_guard_sync #(.W(NFLAG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_w),
        .sync_o  (syn_w)
    );

    assign supply_w    = syn_w[F_OV] | syn_w[F_UV];
    assign mute_rise_w = syn_w[F_MUTE] & ~st_q.mute_prev;
    assign cause_w     = supply_w | syn_w[F_OCS] | st_q.oc_lat | st_q.spk_blk
                       | syn_w[F_MUTE] | syn_w[F_SLEEP];

    always_comb begin
        st_d           = st_q;
        st_d.mute_prev = syn_w[F_MUTE];
        if (syn_w[F_OCS])     st_d.oc_lat = 1'b1;
        else if (mute_rise_w) st_d.oc_lat = 1'b0;
        if (syn_w[F_SPK0] && syn_w[F_SPK1]) st_d.spk_blk = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{oc_lat: 1'b0, spk_blk: 1'b1, mute_prev: 1'b0};
        else        st_q <= st_d;
    end

    amp_guard_timer #(.DLY(DLY)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold_i  (cause_w),
        .ready_o (ready_w)
    );

    assign stage_en_o   = ready_w & ~cause_w;
    assign hmute_o      = ~stage_en_o;
    assign gain_cut_o   = syn_w[F_OCL];
    assign clip_ind_o   = syn_w[F_CLIP];
    assign lowpwr_o     = syn_w[F_SLEEP];
    assign oc_latched_o = st_q.oc_lat;
    assign spk_wait_o   = st_q.spk_blk;
    assign supply_flt_o = supply_w;

    AST_SUPPLY_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        supply_w |-> !stage_en_o && hmute_o) else $error("supply"); // R1
    AST_OC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.oc_lat && !mute_rise_w |=> st_q.oc_lat) else $error("oc"); // R3
    AST_MUTE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        syn_w[F_MUTE] |-> hmute_o) else $error("mute"); // R4
    AST_QUIET_BEFORE_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stage_en_o) |-> $past(!cause_w)) else $error("delay"); // R5
    AST_SPK_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.spk_blk |-> !stage_en_o) else $error("spk"); // R6
    AST_SLEEP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        syn_w[F_SLEEP] |-> lowpwr_o && !stage_en_o) else $error("sleep"); // R7
endmodule

// File: tb/amp_guard_bench.sv
module amp_guard_bench;
    localparam int DLY = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ovp = 0, uvp = 0, ocl = 0, ocs = 0, clip = 0, mute = 0, sleep = 0;
    logic [1:0] spk = 2'b01;
    logic stage_en, hmute, gain_cut, clip_ind, lowpwr, oc_latched, spk_wait, supply_flt;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    amp_guard #(.CLK_HZ(50_000), .UNMUTE_MS(1)) u_amp_guard (
        .clk(clk), .rst_n(rst_n), .ovp_i(ovp), .uvp_i(uvp), .ocl_i(ocl), .ocs_i(ocs),
        .spk_ok_i(spk), .clip_i(clip), .mute_i(mute), .sleep_i(sleep),
        .stage_en_o(stage_en), .hmute_o(hmute), .gain_cut_o(gain_cut),
        .clip_ind_o(clip_ind), .lowpwr_o(lowpwr), .oc_latched_o(oc_latched),
        .spk_wait_o(spk_wait), .supply_flt_o(supply_flt)
    );

    // stimulus {ov, uv, ocl, clip, sleep} ; expect {stage_en, gain_cut, clip_ind, lowpwr}
    localparam logic [8:0] VEC [7] = '{
        {5'b00000, 4'b1000},
        {5'b10000, 4'b0000},
        {5'b01000, 4'b0000},
        {5'b00100, 4'b1100},
        {5'b00010, 4'b1010},
        {5'b00001, 4'b0001},
        {5'b00110, 4'b1110}
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        // R10 reset state
        check("R10", {stage_en, hmute, oc_latched, spk_wait}, 4'b0101);
        check("R10 gain", {3'b0, gain_cut}, 4'b0000);
        rst_n = 1'b1;
        step(DLY + 10);
        check("R6 one speaker", {stage_en, hmute, spk_wait, 1'b0}, 4'b0110);
        spk = 2'b11;
        step(3);
        check("R6 both seen", {3'b0, spk_wait}, 4'b0000);
        step(DLY + 2);
        check("R6 start", {stage_en, hmute, 2'b00}, 4'b1000);
        spk = 2'b10;
        step(6);
        check("R6 later loss ignored", {stage_en, spk_wait, 2'b00}, 4'b1000);
        spk = 2'b11;

        for (int i = 0; i < 7; i++) begin
            {ovp, uvp, ocl, clip, sleep} = VEC[i][8:4];
            step(3);
            check($sformatf("R1/R2/R7/R8 vec%0d", i), {stage_en, gain_cut, clip_ind, lowpwr}, VEC[i][3:0]);
            if (VEC[i][3] == 1'b0)
                check("R11 hmute", {3'b0, hmute}, 4'b0001);
            {ovp, uvp, ocl, clip, sleep} = 5'b0;
            step(DLY + 4);
            check("R1 recover", {stage_en, supply_flt, lowpwr, hmute}, 4'b1000);
        end

        // R9 synchronizer latency
        ovp = 1'b1;
        step(1);
        check("R9 one edge", {stage_en, 3'b0}, 4'b1000);
        step(1);
        check("R9 two edges", {stage_en, supply_flt, 2'b0}, 4'b0100);
        ovp = 1'b0;
        step(DLY + 4);

        // R4 mute, R5 exact delay
        mute = 1'b1;
        step(3);
        check("R4 mute", {stage_en, hmute, 2'b0}, 4'b0100);
        mute = 1'b0;
        step(DLY + 1);
        check("R5 before delay", {stage_en, 3'b0}, 4'b0000);
        step(1);
        check("R5 at delay", {stage_en, 3'b0}, 4'b1000);

        // R5 abort and restart
        mute = 1'b1;
        step(3);
        mute = 1'b0;
        step(20);
        mute = 1'b1;
        step(3);
        mute = 1'b0;
        step(DLY + 1);
        check("R5 restart early", {stage_en, 3'b0}, 4'b0000);
        step(1);
        check("R5 restart done", {stage_en, 3'b0}, 4'b1000);

        // R3 latched over-current
        ocs = 1'b1;
        step(3);
        check("R3 trip", {stage_en, hmute, oc_latched, 1'b0}, 4'b0110);
        ocs = 1'b0;
        step(DLY + 10);
        check("R3 held", {stage_en, oc_latched, 2'b0}, 4'b0100);
        ocs = 1'b1;
        mute = 1'b1;
        step(4);
        mute = 1'b0;
        ocs = 1'b0;
        step(DLY + 10);
        check("R3 mute during shutdown", {stage_en, oc_latched, 2'b0}, 4'b0100);
        mute = 1'b1;
        step(4);
        check("R3 cleared", {oc_latched, 3'b0}, 4'b0000);
        mute = 1'b0;
        step(DLY + 4);
        check("R3 resume", {stage_en, hmute, 2'b0}, 4'b1000);

        // R11 combined causes
        sleep = 1'b1;
        mute = 1'b1;
        step(3);
        sleep = 1'b0;
        step(DLY + 4);
        check("R11 mute remains", {stage_en, hmute, 2'b0}, 4'b0100);
        mute = 1'b0;
        step(DLY + 4);
        check("R11 all clear", {stage_en, 3'b0}, 4'b1000);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule